// File: doc/BRIEF.md
# Mains Half-Cycle Window Monitor

This block measures the length of each positive mains half-cycle. An external comparator produces a detect level that is high while the rectified mains is above a small threshold. The block counts ticks of a divided system clock across that high phase. The running count is a wrapping register that starts from a calibration preload. Counting waits for a fixed number of ticks after each start. With these two offsets, a nominal half-cycle ends on a chosen midpoint value (128 with the default parameters).

When the detect level falls, the final count is compared against a tolerance window. The window is narrow or wide, chosen by a select input. Three registered flags report the result: below the window, above the window, and exactly on target. The on-target flag supports field calibration: the preload is raised until a known-good 50 Hz input lands exactly on the midpoint. The flags keep their value until the next half-cycle ends.

Top module: `mfm_halfcycle_mon`

## Requirements
- R1: After reset, `below_win`, `above_win` and `on_target` are all 0.
- R2: A tick occurs every DIV_A*DIV_B system clocks. The first tick comes DIV_A*DIV_B clocks after the synchronised start edge, and only ticks strictly before the synchronised end edge take part. With DIV_A*DIV_B = 2 and a detect high for H clocks, the number of ticks is floor((H-1)/2).
- R3: At each half-cycle start, the count register loads `cal_preload`, so the final value is (cal_preload + counted ticks) mod 2^CNT_W.
- R4: The first START_DLY ticks (default 118) after a start are not counted. If a half-cycle has START_DLY or fewer ticks, the final value equals `cal_preload`.
- R5: The count is CNT_W bits wide (default 8) and wraps modulo 2^CNT_W. The final value is (cal_preload + ticks - START_DLY) mod 256 whenever ticks > START_DLY.
- R6: With `wide_sel` = 0 at the end edge, the window is TARGET±NARROW_HALF (118..138). `below_win` = 1 iff final < 118, and `above_win` = 1 iff final > 138. Both bounds are inside the window.
- R7: With `wide_sel` = 1 at the end edge, the window is TARGET±WIDE_HALF (78..178). The below and above rules are the same as in R6.
- R8: `on_target` = 1 iff the final value equals TARGET (128). When it is 1, `below_win` and `above_win` are both 0.
- R9: The flags change only when a half-cycle ends. While detect is high, and while it stays low, they keep the previous result.
- R10: `detect_raw` passes through a two-flop synchroniser, which delays both edges by the same amount. The new flags appear on the third rising clock edge after the first edge that samples detect low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| detect_raw | input | 1 | Asynchronous half-cycle detect, high during the half-cycle |
| cal_preload | input | CNT_W | Calibration value loaded into the counter at each start |
| wide_sel | input | 1 | Window select: 0 narrow (±10), 1 wide (±50) |
| below_win | output | 1 | Last half-cycle final value below the lower bound |
| above_win | output | 1 | Last half-cycle final value above the upper bound |
| on_target | output | 1 | Last half-cycle final value equal to the midpoint |

## Verification
Any fault in the prescaler, the start-delay down-counter or the wrapping count moves the final value. That shows up in the flags three clocks after detect falls, at the end of the affected half-cycle. The bench places half-cycle lengths exactly one count inside and one count outside each bound, so an off-by-one tick, a wrong delay or a wrong bound flips a flag. A flag that moves while a half-cycle is still running is caught by a check in the middle of the high phase.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_COUNT = 2'd2,
      ST_FLUSH = 2'd3
   } mon_state_t;
endpackage

// File: rtl/mfm_sync.sv
module mfm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic rise,
   output logic fall
);
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], d_in};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
   assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/mfm_prescale.sv
module mfm_prescale #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (en)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign tick = en && (cnt == LAST);
endmodule

// File: rtl/mfm_period_ctr.sv
module mfm_period_ctr
   import mfm_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int START_DLY = 118
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             fall,
   input  logic             tick,
   input  logic [CNT_W-1:0] cal,
   output logic             done,
   output logic [CNT_W-1:0] stop_val,
   output mon_state_t       st_o
);
   localparam int DLY_W = $clog2(START_DLY + 1);
   localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(START_DLY);
   localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

   mon_state_t       st;
   logic [DLY_W-1:0] dly;
   logic [CNT_W-1:0] count;
   logic             active;

   assign active = (st == ST_HOLD) || (st == ST_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         dly   <= '0;
         count <= '0;
      end else if (rise) begin
         st    <= ST_HOLD;
         dly   <= DLY_INIT;
         count <= cal;
      end else begin
         unique case (st)
            ST_HOLD: begin
               if (fall) st <= ST_FLUSH;
               else if (tick) begin
                  dly <= dly - 1'b1;
                  if (dly == DLY_ONE) st <= ST_COUNT;
               end
            end
            ST_COUNT: begin
               if (fall)      st    <= ST_FLUSH;
               else if (tick) count <= count + 1'b1;
            end
            ST_FLUSH: begin
               count <= '0;
               st    <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign done     = fall && active;
   assign stop_val = count;
   assign st_o     = st;
endmodule

// File: rtl/mfm_window.sv
module mfm_window #(
   parameter int CNT_W       = 8,
   parameter int TARGET      = 128,
   parameter int NARROW_HALF = 10,
   parameter int WIDE_HALF   = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [CNT_W-1:0] stop_val,
   input  logic             wide_sel,
   output logic             below,
   output logic             above,
   output logic             on_tgt
);
   localparam logic [CNT_W-1:0] LO_N = CNT_W'(TARGET - NARROW_HALF);
   localparam logic [CNT_W-1:0] HI_N = CNT_W'(TARGET + NARROW_HALF);
   localparam logic [CNT_W-1:0] LO_W = CNT_W'(TARGET - WIDE_HALF);
   localparam logic [CNT_W-1:0] HI_W = CNT_W'(TARGET + WIDE_HALF);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(TARGET);

   logic [CNT_W-1:0] lo, hi;

   assign lo = wide_sel ? LO_W : LO_N;
   assign hi = wide_sel ? HI_W : HI_N;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         below  <= 1'b0;
         above  <= 1'b0;
         on_tgt <= 1'b0;
      end else if (done) begin
         below  <= stop_val < lo;
         above  <= stop_val > hi;
         on_tgt <= stop_val == MID;
      end
   end
endmodule

// File: rtl/mfm_halfcycle_mon.sv
module mfm_halfcycle_mon
   import mfm_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int DIV_A       = 2,
   parameter int DIV_B       = 4,
   parameter int START_DLY   = 118,
   parameter int TARGET      = 128,
   parameter int NARROW_HALF = 10,
   parameter int WIDE_HALF   = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             detect_raw,
   input  logic [CNT_W-1:0] cal_preload,
   input  logic             wide_sel,
   output logic             below_win,
   output logic             above_win,
   output logic             on_target
);
   localparam int TICK_DIV = DIV_A * DIV_B;

   if (CNT_W < 2) begin : g_bad_w
      $error("CNT_W must be at least 2");
   end
   if (DIV_A < 1 || DIV_B < 1) begin : g_bad_div
      $error("divider ratios must be at least 1");
   end
   if (START_DLY < 1) begin : g_bad_dly
      $error("START_DLY must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NARROW_HALF > WIDE_HALF || TARGET - WIDE_HALF < 0
       || TARGET + WIDE_HALF >= (1 << CNT_W)) begin : g_bad_win
      $error("window bounds must fit inside the count range");
   end

   logic             rise, fall, tick_a, tick, done;
   logic [CNT_W-1:0] stop_val;
   mon_state_t       st;

   mfm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(detect_raw), .rise(rise), .fall(fall)
   );

   if (DIV_A == 1) begin : g_pa_bypass
      assign tick_a = 1'b1;
   end else begin : g_pa
      mfm_prescale #(.DIV(DIV_A)) u_pa (
         .clk(clk), .rst_n(rst_n), .clr(rise), .en(1'b1), .tick(tick_a)
      );
   end

   if (DIV_B == 1) begin : g_pb_bypass
      assign tick = tick_a;
   end else begin : g_pb
      mfm_prescale #(.DIV(DIV_B)) u_pb (
         .clk(clk), .rst_n(rst_n), .clr(rise), .en(tick_a), .tick(tick)
      );
   end

   mfm_period_ctr #(.CNT_W(CNT_W), .START_DLY(START_DLY)) u_ctr (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .tick(tick),
      .cal(cal_preload), .done(done), .stop_val(stop_val), .st_o(st)
   );

   mfm_window #(
      .CNT_W(CNT_W), .TARGET(TARGET),
      .NARROW_HALF(NARROW_HALF), .WIDE_HALF(WIDE_HALF)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .done(done), .stop_val(stop_val),
      .wide_sel(wide_sel), .below(below_win), .above(above_win),
      .on_tgt(on_target)
   );
endmodule

// File: rtl/mfm_halfcycle_mon_chk.sv
module mfm_halfcycle_mon_chk
   import mfm_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int TICK_DIV = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rise,
   input logic             fall,
   input logic             tick,
   input logic             done,
   input mon_state_t       st,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cal,
   input logic             below,
   input logic             above,
   input logic             on_tgt
);
   // R3: a start loads the calibration preload
   p_preload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> count == $past(cal));

   // R4: count frozen during the start delay
   p_delay_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && !rise) |=> count == $past(count));

   // R5: each counted tick adds one, wrapping
   p_wrap_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COUNT && tick && !rise && !fall)
      |=> count == CNT_W'($past(count) + 1'b1));

   // R8: on target excludes both out-of-window flags
   p_target_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      on_tgt |-> (!below && !above));

   // R9: flags move only after an end event
   p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable({below, above, on_tgt}));

   // R2: ticks are never back to back when the divide ratio exceeds one
   if (TICK_DIV > 1) begin : g_gap
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

bind mfm_halfcycle_mon mfm_halfcycle_mon_chk #(
   .CNT_W(CNT_W), .TICK_DIV(DIV_A * DIV_B)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .tick(tick),
   .done(done), .st(st), .count(stop_val), .cal(cal_preload),
   .below(below_win), .above(above_win), .on_tgt(on_target)
);

// File: tb/sim_mfm_halfcycle_mon.sv
`timescale 1ns/1ps
module sim_mfm_halfcycle_mon;
   localparam int NV = 10;
   // ticks, window select, expected final value (cal = 0, delay 118)
   localparam int V_N   [NV] = '{2550, 2560, 2561, 2540, 2539,
                                 2600, 2601, 2500, 2499, 2600};
   localparam int V_SEL [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 0};
   localparam int V_STOP[NV] = '{128, 138, 139, 118, 117,
                                 178, 179, 78, 77, 178};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       detect_raw = 1'b0;
   logic [7:0] cal_preload = 8'd0;
   logic       wide_sel = 1'b0;
   logic       below_win, above_win, on_target;
   int         n_checks = 0;
   int         n_err = 0;

   always #5 clk = ~clk;

   mfm_halfcycle_mon #(.DIV_A(1), .DIV_B(2)) u0 (
      .clk(clk), .rst_n(rst_n), .detect_raw(detect_raw),
      .cal_preload(cal_preload), .wide_sel(wide_sel),
      .below_win(below_win), .above_win(above_win), .on_target(on_target)
   );

   function automatic logic [2:0] exp_flags(input int stop, input int sel);
      int lo, hi;
      lo = sel ? 78 : 118;
      hi = sel ? 178 : 138;
      return {stop < lo, stop > hi, stop == 128};
   endfunction

   task automatic chk(input string req, input logic [2:0] exp);
      n_checks++;
      if ({below_win, above_win, on_target} !== exp) begin
         n_err++;
         $display("FAIL %s: flags {below,above,on} actual=%b expected=%b",
                  req, {below_win, above_win, on_target}, exp);
      end
   endtask

   task automatic half(input int hi_clks, input int cal, input int sel);
      @(negedge clk);
      cal_preload = 8'(cal);
      wide_sel    = sel[0];
      detect_raw  = 1'b1;
      repeat (hi_clks) @(negedge clk);
      detect_raw = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset state", 3'b000);

      for (int i = 0; i < NV; i++) begin
         string lbl;
         lbl = (V_SEL[i] != 0) ? "R7 wide window" : "R6 narrow window";
         if (V_STOP[i] == 128) lbl = "R8 on target";
         half(2 * V_N[i] + 1, 0, V_SEL[i]);
         chk(lbl, exp_flags(V_STOP[i], V_SEL[i]));
      end

      // R3: preload 28 with 2522 ticks lands on 128
      half(2 * 2522 + 1, 28, 0);
      chk("R3 preload", exp_flags(128, 0));

      // R5: wrap, 2400 ticks -> 234 ; 2700 ticks -> 22
      half(2 * 2400 + 1, 0, 1);
      chk("R5 wrap high", exp_flags(234, 1));
      half(2 * 2700 + 1, 0, 1);
      chk("R5 wrap low", exp_flags(22, 1));

      // R4: delay suppresses counting
      half(2 * 50 + 1, 128, 0);
      chk("R4 short half-cycle", exp_flags(128, 0));
      half(2 * 119 + 1, 128, 0);
      chk("R4 one tick past delay", exp_flags(129, 0));
      half(2 * 118 + 1, 128, 0);
      chk("R4 exactly delay ticks", exp_flags(128, 0));

      // R2: high of 5100 clocks -> 2549 ticks ; 5102 -> 2550 ticks
      half(5100, 0, 0);
      chk("R2 tick count even length", exp_flags(127, 0));
      half(5102, 0, 0);
      chk("R2 tick count long length", exp_flags(128, 0));

      // R9 / R10: flags hold mid cycle, then update after sync latency
      half(2 * 2561 + 1, 0, 0);
      chk("R9 setup above", exp_flags(139, 0));
      @(negedge clk);
      detect_raw = 1'b1;
      repeat (1000) @(negedge clk);
      chk("R9 flags hold while high", exp_flags(139, 0));
      repeat (2 * 2550 + 1 - 1000) @(negedge clk);
      detect_raw = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 flags not yet updated", exp_flags(139, 0));
      @(negedge clk);
      chk("R10 flags updated", exp_flags(128, 0));
      repeat (20) @(negedge clk);
      chk("R9 flags hold while low", exp_flags(128, 0));

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule